// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a synchronous cache RAM whose 18-bit word is split into two 9-bit lanes. Lane A occupies bits 8:0 and lane B bits 17:9, and each lane carries 8 data bits and 1 parity bit. Every synchronous control, address and data input is captured on the rising clock edge. Read data is not registered on the way out. It flows from the registered address through the array to the read bus. The first beat of a burst therefore shows up in the cycle after the strobe, and each further beat follows one cycle later, giving a 2-1-1-1 pattern.

A burst starts with one of two address strobes. The processor strobe, `procStrbN`, always begins a read. The controller strobe, `ctrlStrbN`, can begin either a read or a write. A 2-bit counter then steps through the four words of the aligned group, in linear or interleaved order. The advance input decides in which cycles the counter moves. Writes can store the whole word at once, or only the lanes that are enabled. Three chip enables select the device: one pipelines the access and two expand the depth. The output enable and the sleep input act on the read bus without waiting for a clock edge.

Top module: `syncBurstSram`

## Requirements
- R1: While `rstN` is low and in the first cycle after it is released, `dqOutEn` is 0.
- R2: A controller-strobe cycle with `gwN`=0 on a selected device writes all 18 bits of `dqIn` at `addrIn`. A controller-strobe cycle with write disabled reads that address, and the word appears on `dqOut` with `dqOutEn`=1 right after the next rising edge.
- R3: With `gwN`=1 and `bweN`=0, only the lanes whose `bwN` bit is 0 are written. `bwN[0]` controls lane A (bits 8:0) and `bwN[1]` controls lane B (bits 17:9). The other lane keeps its old value.
- R4: With `gwN`=1 and either `bweN`=1 or `bwN`=2'b11, the cycle is a read and the memory is left unchanged.
- R5: With `modeIlv`=0, each cycle that has `advN`=0 and no strobe moves the burst on. The low two address bits go through base, base+1, base+2, base+3, modulo 4. The upper bits stay fixed. A write in such a cycle goes to the advanced address.
- R6: With `modeIlv`=1, the low two address bits go through base XOR 0, 1, 2, 3.
- R7: A cycle with no strobe and `advN`=1 keeps the current burst address. The same word is read again.
- R8: The device is selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0, sampled at a strobe. A strobe while deselected ends the burst: no write happens and `dqOutEn` stays 0 until the next selected strobe.
- R9: A processor strobe counts only when `ce1N`=0. It takes priority over the controller strobe and always reads, ignoring the write enables in that cycle. A processor strobe with `ce1N`=1 is ignored, and the burst carries on.
- R10: `oeN`=1 forces `dqOutEn` to 0 in the same cycle, with no clock edge needed. `oeN`=0 enables the bus again in the same cycle for a pending read.
- R11: While `sleep`=1, `dqOutEn` is 0 and every access is ignored. The memory contents are kept through sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset of the control state |
| addrIn | input | ADDR_W | Word address |
| procStrbN | input | 1 | Processor address strobe, active low |
| ctrlStrbN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| ce1N | input | 1 | Pipelining chip enable, active low |
| ce2 | input | 1 | Depth-expansion enable, active high |
| ce3N | input | 1 | Depth-expansion enable, active low |
| gwN | input | 1 | Global (whole-word) write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 2 | Per-lane write enables, active low (bit 0 lane A) |
| modeIlv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dqIn | input | 18 | Write data |
| dqOut | output | 18 | Read data, zero when not driven |
| dqOutEn | output | 1 | High while the read bus is driven |

## Verification
The bench builds the block with `ADDR_W`=6, which gives 64 words. Every group of four words used by the bursts fits inside a small model array that the bench holds itself. Keeping the array this small lets the bench prefill whole groups cheaply, so both burst orders can be checked through the wrap-around back to the start of a group. The same array lets the bench confirm that deselected, sleeping and processor-strobe cycles leave earlier writes untouched.

// File: rtl/sramPkg.sv
package sramPkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic             wrEn;
    logic [LANES-1:0] laneWr;
    logic             rdEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/burstSeq.sv
module burstSeq #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = sramPkg::BEAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic              modeIlv,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  cntQ;
  logic              ilvQ;
  logic [CNT_W-1:0]  cntNext;

  function automatic logic [CNT_W-1:0] beatLow(input logic [CNT_W-1:0] b,
                                               input logic [CNT_W-1:0] c,
                                               input logic ilv);
    return ilv ? (b ^ c) : (b + c);
  endfunction

  assign cntNext = cntQ + 1'b1;
  assign curAddr = {baseQ[ADDR_W-1 -: HI_W], beatLow(baseQ[CNT_W-1:0], cntQ, ilvQ)};

  always_comb begin
    if (load)      effAddr = loadAddr;
    else if (step) effAddr = {baseQ[ADDR_W-1 -: HI_W], beatLow(baseQ[CNT_W-1:0], cntNext, ilvQ)};
    else           effAddr = curAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      ilvQ  <= 1'b0;
    end else if (load) begin
      baseQ <= loadAddr;
      cntQ  <= '0;
      ilvQ  <= modeIlv;
    end else if (step) begin
      cntQ  <= cntNext;
    end
  end
endmodule

// File: rtl/sramCtrl.sv
module sramCtrl
  import sramPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrbN,
  input  logic             ctrlStrbN,
  input  logic             advN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             sleep,
  output logic             loadBurst,
  output logic             stepBurst,
  output logic             burstActive,
  output ctrlStrobes_t     strobes
);
  logic             procStart;
  logic             ctrlStart;
  logic             anyStart;
  logic             selHit;
  logic             access;
  logic [LANES-1:0] laneMask;
  logic             wrOk;
  logic             activeQ;

  assign procStart = !procStrbN && !ce1N;
  assign ctrlStart = !ctrlStrbN;
  assign anyStart  = (procStart || ctrlStart) && !sleep;
  assign selHit    = !ce1N && ce2 && !ce3N;
  assign access    = !sleep && (anyStart ? selHit : activeQ);

  always_comb begin
    if (!gwN)       laneMask = '1;
    else if (!bweN) laneMask = ~bwN;
    else            laneMask = '0;
  end

  assign wrOk      = access && !procStart && (|laneMask);
  assign loadBurst = anyStart && selHit;
  assign stepBurst = !sleep && !anyStart && activeQ && !advN;

  always_comb begin
    strobes.wrEn   = wrOk;
    strobes.laneWr = wrOk ? laneMask : '0;
    strobes.rdEn   = access && !wrOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         activeQ <= 1'b0;
    else if (anyStart) activeQ <= selHit;
  end

  assign burstActive = activeQ;
endmodule

// File: rtl/sramDatapath.sv
module sramDatapath
  import sramPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] dqIn,
  input  logic              oeN,
  input  logic              sleep,
  output logic [WORD_W-1:0] dqOut,
  output logic              dqOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rdWord;
  logic              rdValidQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.wrEn && strobes.laneWr[g])
        laneMem[wrAddr] <= dqIn[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValidQ <= 1'b0;
    else       rdValidQ <= strobes.rdEn;
  end

  assign dqOutEn = rdValidQ && !oeN && !sleep;
  assign dqOut   = dqOutEn ? rdWord : '0;
endmodule

// File: rtl/syncBurstSram.sv
module syncBurstSram
  import sramPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrbN,
  input  logic              ctrlStrbN,
  input  logic              advN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              modeIlv,
  input  logic              oeN,
  input  logic              sleep,
  input  logic [WORD_W-1:0] dqIn,
  output logic [WORD_W-1:0] dqOut,
  output logic              dqOutEn
);
  ctrlStrobes_t      strobes;
  logic              loadBurst;
  logic              stepBurst;
  logic              burstActive;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] curAddr;

  sramCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN),
    .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .sleep(sleep), .loadBurst(loadBurst), .stepBurst(stepBurst),
    .burstActive(burstActive), .strobes(strobes)
  );

  burstSeq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rstN(rstN), .load(loadBurst), .step(stepBurst),
    .modeIlv(modeIlv), .loadAddr(addrIn), .effAddr(effAddr), .curAddr(curAddr)
  );

  sramDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(effAddr),
    .rdAddr(curAddr), .dqIn(dqIn), .oeN(oeN), .sleep(sleep),
    .dqOut(dqOut), .dqOutEn(dqOutEn)
  );
endmodule

// File: rtl/sramChecker.sv
module sramChecker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrbN,
  input logic              ctrlStrbN,
  input logic              advN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              oeN,
  input logic              sleep,
  input logic              dqOutEn,
  input logic              burstActive,
  input logic [ADDR_W-1:0] curAddr
);
  // R8
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && (!ctrlStrbN || (!procStrbN && !ce1N)) && !(!ce1N && ce2 && !ce3N))
      |=> !dqOutEn);

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dqOutEn);

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqOutEn);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procStrbN && ctrlStrbN && advN) |=> $stable(curAddr));

  // R5
  burst_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstActive && procStrbN && ctrlStrbN && !advN && !sleep)
      |=> $stable(curAddr[ADDR_W-1:2]));

  // R9
  proc_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrbN && !ce1N && ce2 && !ce3N && !sleep)
      |=> (dqOutEn || oeN || sleep));
endmodule

bind syncBurstSram sramChecker #(.ADDR_W(ADDR_W)) u_sramChk (
  .clk(clk), .rstN(rstN), .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN),
  .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .oeN(oeN), .sleep(sleep),
  .dqOutEn(dqOutEn), .burstActive(burstActive), .curAddr(curAddr)
);

// File: tb/test_syncBurstSram.sv
`timescale 1ns/100ps
module test_syncBurstSram;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          procStrbN = 1'b1, ctrlStrbN = 1'b1, advN = 1'b1;
  logic          ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic          gwN = 1'b1, bweN = 1'b1;
  logic [1:0]    bwN = 2'b11;
  logic          modeIlv = 1'b0, oeN = 1'b0, sleep = 1'b0;
  logic [17:0]   dqIn = '0;
  logic [17:0]   dqOut;
  logic          dqOutEn;

  logic [17:0]   model [64];
  int            nChecks = 0;
  int            nFails = 0;
  bit            finished = 1'b0;

  syncBurstSram #(.ADDR_W(AW)) i_syncBurstSram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrbN(procStrbN),
    .ctrlStrbN(ctrlStrbN), .advN(advN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .modeIlv(modeIlv), .oeN(oeN),
    .sleep(sleep), .dqIn(dqIn), .dqOut(dqOut), .dqOutEn(dqOutEn)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    procStrbN = 1'b1; ctrlStrbN = 1'b1; advN = 1'b1;
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    gwN = 1'b1; bweN = 1'b1; bwN = 2'b11;
    oeN = 1'b0; sleep = 1'b0;
  endtask

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeFull(input int a, input logic [17:0] d);
    idle(); ctrlStrbN = 1'b0; addrIn = AW'(a); gwN = 1'b0; dqIn = d;
    tick(); idle();
    model[a] = d;
  endtask

  task automatic readStart(input int a);
    idle(); ctrlStrbN = 1'b0; addrIn = AW'(a);
    tick(); idle();
  endtask

  task automatic readWord(input string req, input int a);
    readStart(a);
    chk(req, {17'd0, dqOutEn}, 18'd1);
    chk(req, dqOut, model[a]);
  endtask

  task automatic tReset();
    rstN = 1'b0; idle();
    tick();
    chk("R1 during reset", {17'd0, dqOutEn}, 18'd0);
    tick();
    rstN = 1'b1;
    tick();
    chk("R1 after reset", {17'd0, dqOutEn}, 18'd0);
  endtask

  task automatic tGlobalWrite();
    writeFull(5, 18'h2A5A5);
    readWord("R2 full write", 5);
    writeFull(6, 18'h1C3E1);
    readWord("R2 second word", 6);
  endtask

  task automatic tByteWrite();
    writeFull(8, 18'h00000);
    idle(); ctrlStrbN = 1'b0; addrIn = 6'd8; bweN = 1'b0; bwN = 2'b10; dqIn = 18'h3FFFF;
    tick(); idle(); model[8] = 18'h001FF;
    readWord("R3 lane A only", 8);
    idle(); ctrlStrbN = 1'b0; addrIn = 6'd8; bweN = 1'b0; bwN = 2'b01; dqIn = 18'h2AA00;
    tick(); idle(); model[8] = 18'h2ABFF;
    readWord("R3 lane B only", 8);
    idle(); ctrlStrbN = 1'b0; addrIn = 6'd8; bweN = 1'b1; bwN = 2'b00; dqIn = 18'h12345;
    tick(); idle();
    chk("R4 no write enable reads", dqOut, model[8]);
    idle(); ctrlStrbN = 1'b0; addrIn = 6'd8; bweN = 1'b0; bwN = 2'b11; dqIn = 18'h12345;
    tick(); idle();
    readWord("R4 empty lane mask", 8);
  endtask

  task automatic tBursts();
    for (int i = 16; i < 20; i++) writeFull(i, 18'(32'h10100 + i));
    modeIlv = 1'b0;
    readStart(18);
    chk("R5 linear beat0", dqOut, model[18]);
    advN = 1'b0; tick(); chk("R5 linear beat1", dqOut, model[19]);
    tick(); chk("R5 linear wrap", dqOut, model[16]);
    tick(); chk("R5 linear beat3", dqOut, model[17]);
    idle();
    modeIlv = 1'b1;
    readStart(17);
    chk("R6 ilv beat0", dqOut, model[17]);
    advN = 1'b0; tick(); chk("R6 ilv beat1", dqOut, model[16]);
    tick(); chk("R6 ilv beat2", dqOut, model[19]);
    tick(); chk("R6 ilv beat3", dqOut, model[18]);
    idle(); modeIlv = 1'b0;
  endtask

  task automatic tWait();
    readStart(16);
    tick(); chk("R7 wait holds", dqOut, model[16]);
    procStrbN = 1'b0; ce1N = 1'b1; addrIn = 6'd40;
    tick(); idle();
    chk("R9 strobe with ce1N high ignored", dqOut, model[16]);
    advN = 1'b0; tick(); idle();
    chk("R7 advance after wait", dqOut, model[17]);
  endtask

  task automatic tBurstWrite();
    writeFull(20, 18'h0AAAA);
    idle(); advN = 1'b0; gwN = 1'b0; dqIn = 18'h15555;
    tick(); idle(); model[21] = 18'h15555;
    readWord("R5 burst write beat1", 21);
    readWord("R5 burst write beat0", 20);
  endtask

  task automatic tChipSelect();
    idle(); ctrlStrbN = 1'b0; addrIn = 6'd5; ce2 = 1'b0;
    tick(); idle();
    chk("R8 ce2 low deselects", {17'd0, dqOutEn}, 18'd0);
    advN = 1'b0; tick(); idle();
    chk("R8 burst stays ended", {17'd0, dqOutEn}, 18'd0);
    ctrlStrbN = 1'b0; addrIn = 6'd5; ce3N = 1'b1; gwN = 1'b0; dqIn = 18'h3F00F;
    tick(); idle();
    chk("R8 ce3N high deselects", {17'd0, dqOutEn}, 18'd0);
    readWord("R8 deselected write ignored", 5);
  endtask

  task automatic tProcStrobe();
    idle(); procStrbN = 1'b0; addrIn = 6'd6; gwN = 1'b0; dqIn = 18'h00F0F;
    tick(); idle();
    chk("R9 proc strobe reads", dqOut, model[6]);
    procStrbN = 1'b0; ctrlStrbN = 1'b0; addrIn = 6'd6; gwN = 1'b0; dqIn = 18'h0F0F0;
    tick(); idle();
    chk("R9 proc priority read", dqOut, model[6]);
    readWord("R9 no write stored", 6);
  endtask

  task automatic tOutputEnable();
    readStart(5);
    oeN = 1'b1; #1;
    chk("R10 oe off same cycle", {17'd0, dqOutEn}, 18'd0);
    oeN = 1'b0; #1;
    chk("R10 oe on same cycle", dqOut, model[5]);
    idle();
  endtask

  task automatic tSleep();
    readStart(5);
    sleep = 1'b1; #1;
    chk("R11 sleep tristates", {17'd0, dqOutEn}, 18'd0);
    ctrlStrbN = 1'b0; addrIn = 6'd5; gwN = 1'b0; dqIn = 18'h3FFFF;
    tick();
    chk("R11 off while asleep", {17'd0, dqOutEn}, 18'd0);
    idle();
    readWord("R11 contents retained", 5);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    tReset();
    for (int i = 0; i < 64; i++) writeFull(i, '0);
    tGlobalWrite();
    tByteWrite();
    tBursts();
    tWait();
    tBurstWrite();
    tChipSelect();
    tProcStrobe();
    tOutputEnable();
    tSleep();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule